// File: doc/BRIEF.md
# Strap-Latched Configuration Retry Controller

This block is the status and control register behind a bus interface that must hold off configuration accesses from the host until local firmware is ready. When bus reset is released, it captures several strap inputs. One strap decides whether the interface starts by answering every configuration cycle with a Retry. A second strap decides whether a firmware watchdog is armed. Two active-low strap pins decide whether each of two local processor cores starts held in reset. A last strap records whether the link was brought up as 64 bits wide.

Firmware releases the host by writing a one to the retry field. If firmware does not do this in time, the watchdog releases the flag itself. When the watchdog does the release, it also clears its own enable bit. Afterwards, the enable bit shows which agent opened the interface. Software releases the cores by clearing their hold bits. A self-clearing control bit returns the hold bits to their strap defaults.

Top module: `cfg_retry_ctl`

## Requirements
- R1: While `rst` is high, the retry flag is loaded from `strap_retry` (1 = set). After release it is readable in bit 0 of `reg_rdata`. `reg_rdata` and `cfg_retry` are 0 while in reset, and `reg_rdata` shows the state one cycle late.
- R2: `cfg_retry` is high in the cycle after a cycle in which `cfg_cycle` was high while the retry flag was set. Otherwise it is low.
- R3: The watchdog enable bit (bit 1, read-only) is loaded from `strap_tmr_en` during reset (1 = enabled).
- R4: When the enable bit and the retry flag are both set, both clear on the TMO_CYCLES-th rising clock edge after the reset release. TMO_CYCLES defaults to CLK_HZ*4/10, which is 400 ms.
- R5: A write with bit 0 set clears the retry flag on that edge, and the enable bit keeps its value. If this write lands on the expiry edge, firmware wins and the enable bit stays 1. Once clear, the flag is never set again by anything except reset.
- R6: With the enable bit at 0, the retry flag stays set until firmware clears it.
- R7: Each hold bit `core_hold[i]` (register bits 3:2, bit 2 for core 0) is loaded during reset as the inverse of `strap_core_n[i]`.
- R8: A write clears every hold bit whose data bit is 1. Writing 0 leaves a hold bit unchanged, and no write can set a hold bit.
- R9: Writing 1 to bit 8 reloads the hold bits with the values captured during the last reset. This reload takes priority over a clear in the same write. Bit 8 always reads 0.
- R10: Bit 4 (read-only) is loaded with `strap_req64_n` during reset: 0 means the 64-bit request was asserted. Writes do not change it.
- R11: Register bits 31:9 and 7:5 read 0. Writes to bit 1 and bit 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Bus reset, synchronous, active high; straps are sampled while it is high |
| strap_retry | input | 1 | Retry-at-start strap, 1 = start retrying |
| strap_tmr_en | input | 1 | Watchdog enable strap, 1 = armed |
| strap_core_n | input | 2 | Active-low per-core hold straps |
| strap_req64_n | input | 1 | Active-low 64-bit request strap |
| cfg_cycle | input | 1 | A configuration cycle is presented this cycle |
| cfg_retry | output | 1 | Registered: answer the configuration cycle with Retry |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register contents |
| core_hold | output | 2 | Per-core reset hold |

## Verification
The bench builds the block with TMO_CYCLES set to 6, so every timeout completes within a dozen cycles. This lets the bench sweep all 32 strap combinations. Each combination runs three firmware behaviours: no release, a release well before expiry, and a release on the expiry edge itself. For every cycle, the expected retry flag, enable bit and `cfg_retry` are computed from the edge index. After each run, clear, reload and write-everything patterns probe the hold bits and the read-only fields.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
  localparam int REG_W     = 32;
  localparam int N_CORES   = 2;
  localparam int RETRY_BIT = 0;
  localparam int TMR_BIT   = 1;
  localparam int HOLD_LSB  = 2;
  localparam int NARROW_BIT = 4;
  localparam int RELOAD_BIT = 8;

  typedef struct packed {
    logic               narrow;
    logic [N_CORES-1:0] hold;
    logic               tmr;
    logic               retry;
  } csr_t;
endpackage

// File: rtl/cfg_fw_timer.sv
module cfg_fw_timer #(
  parameter int TMO_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && !rst && (cnt == LAST);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == '0);
endmodule

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch
  import cfg_retry_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] strap_core_n,
  output logic [N_CORES-1:0] dflt_hold
);
  always_ff @(posedge clk) begin
    if (rst) dflt_hold <= ~strap_core_n;
  end

  // R9
  dflt_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dflt_hold));
endmodule

// File: rtl/cfg_csr_fields.sv
module cfg_csr_fields
  import cfg_retry_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_retry,
  input  logic               strap_tmr_en,
  input  logic [N_CORES-1:0] strap_core_n,
  input  logic               strap_req64_n,
  input  logic [N_CORES-1:0] dflt_hold,
  input  logic               clr_retry,
  input  logic [N_CORES-1:0] clr_hold,
  input  logic               reload_hold,
  input  logic               expire,
  output csr_t               csr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      csr.retry  <= strap_retry;
      csr.tmr    <= strap_tmr_en;
      csr.hold   <= ~strap_core_n;
      csr.narrow <= strap_req64_n;
    end else begin
      if (clr_retry) begin
        csr.retry <= 1'b0;
      end else if (expire) begin
        csr.retry <= 1'b0;
        csr.tmr   <= 1'b0;
      end
      if (reload_hold) csr.hold <= dflt_hold;
      else             csr.hold <= csr.hold & ~clr_hold;
    end
  end

  // R5
  retry_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !csr.retry |=> !csr.retry);
  // R4
  tmr_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csr.tmr) |-> !csr.retry);
  // R8
  hold_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !reload_hold |=> (csr.hold & ~$past(csr.hold)) == '0);
  // R10
  narrow_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(csr.narrow));
endmodule

// File: rtl/cfg_retry_ctl.sv
module cfg_retry_ctl
  import cfg_retry_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int TMO_CYCLES = CLK_HZ / 10 * 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_retry,
  input  logic               strap_tmr_en,
  input  logic [N_CORES-1:0] strap_core_n,
  input  logic               strap_req64_n,
  input  logic               cfg_cycle,
  output logic               cfg_retry,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [N_CORES-1:0] core_hold
);
  csr_t               csr;
  logic [N_CORES-1:0] dflt_hold;
  logic               expire;
  logic               clr_retry;
  logic               reload_hold;
  logic [N_CORES-1:0] clr_hold;
  logic [REG_W-1:0]   rd_next;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign clr_retry    = reg_wr && reg_wdata[RETRY_BIT];
  assign reload_hold  = reg_wr && reg_wdata[RELOAD_BIT];
  assign clr_hold     = reg_wr ? reg_wdata[HOLD_LSB +: N_CORES] : '0;

  cfg_strap_latch u_latch (
    .clk          (clk),
    .rst          (rst),
    .strap_core_n (strap_core_n),
    .dflt_hold    (dflt_hold)
  );

  cfg_fw_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (csr.retry && csr.tmr),
    .expire (expire)
  );

  cfg_csr_fields u_fields (
    .clk           (clk),
    .rst           (rst),
    .strap_retry   (strap_retry),
    .strap_tmr_en  (strap_tmr_en),
    .strap_core_n  (strap_core_n),
    .strap_req64_n (strap_req64_n),
    .dflt_hold     (dflt_hold),
    .clr_retry     (clr_retry),
    .clr_hold      (clr_hold),
    .reload_hold   (reload_hold),
    .expire        (expire),
    .csr           (csr)
  );

  always_comb begin
    rd_next             = '0;
    rd_next[RETRY_BIT]  = csr.retry;
    rd_next[TMR_BIT]    = csr.tmr;
    rd_next[NARROW_BIT] = csr.narrow;
    for (int i = 0; i < N_CORES; i++) rd_next[HOLD_LSB + i] = csr.hold[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      cfg_retry <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      cfg_retry <= cfg_cycle && csr.retry;
    end
  end

  assign core_hold = csr.hold;

  // R2
  retry_answer_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_cycle && csr.retry |=> cfg_retry);
  // R2
  no_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_cycle |=> !cfg_retry);
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:NARROW_BIT+1] == '0);
endmodule

// File: tb/cfg_retry_ctl_bench.sv
`timescale 1ns/1ps
module cfg_retry_ctl_bench;
  localparam int LIM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_retry = 1'b0, strap_tmr_en = 1'b0, strap_req64_n = 1'b0;
  logic [1:0]  strap_core_n = 2'b00;
  logic        cfg_cycle = 1'b0, cfg_retry;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  core_hold;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  cfg_retry_ctl #(.TMO_CYCLES(LIM)) u_cfg_retry_ctl (
    .clk(clk), .rst(rst), .strap_retry(strap_retry), .strap_tmr_en(strap_tmr_en),
    .strap_core_n(strap_core_n), .strap_req64_n(strap_req64_n),
    .cfg_cycle(cfg_cycle), .cfg_retry(cfg_retry), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_hold(core_hold)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(bit r, bit t, logic [1:0] h, bit n);
    return {27'b0, n, h, t, r};
  endfunction

  task automatic wr_check(logic [31:0] d, bit r, bit t, logic [1:0] h, bit n, string req);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    @(negedge clk);
    chk(req, reg_rdata, pack(r, t, h, n));
    chk(req, {30'b0, core_hold}, {30'b0, h});
  endtask

  task automatic run(int c, int m);
    bit sr = c[0], te = c[1], rq = c[4];
    logic [1:0] cn = c[3:2];
    logic [1:0] h = ~cn;
    bit fw = (m != 0);
    int fwe = (m == 1) ? 3 : LIM;
    bit expired = te && sr && !(fw && fwe <= LIM);
    bit pcfg, er, et;
    string lab;
    rst = 1'b1; strap_retry = sr; strap_tmr_en = te; strap_core_n = cn; strap_req64_n = rq;
    cfg_cycle = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state, R7 hold loaded
    chk("R1", {31'b0, cfg_retry}, 32'h0);
    chk("R1", reg_rdata, 32'h0);
    chk("R7", {30'b0, core_hold}, {30'b0, h});
    rst = 1'b0;
    for (int k = 1; k <= 2 * LIM + 2; k++) begin
      int j = k - 1;
      pcfg = (k % 3) != 0;
      cfg_cycle = pcfg;
      reg_wr = fw && (k == fwe);
      reg_wdata = reg_wr ? 32'hFFFF_FEF3 : 32'h0;
      @(negedge clk);
      er = sr && !(fw && fwe <= j) && !(expired && j >= LIM);
      et = te && !(expired && j >= LIM);
      lab = (k == 1) ? "R3" : (m == 0) ? (te ? "R4" : "R6") : "R5";
      chk("R2", {31'b0, cfg_retry}, {31'b0, pcfg && er});
      chk(lab, reg_rdata, pack(er, et, h, rq));
    end
    reg_wr = 1'b0; reg_wdata = '0; cfg_cycle = 1'b0;
    er = sr && !fw && !expired;
    et = te && !expired;
    @(negedge clk);
    // R8 clear core 0 only
    h[0] = 1'b0;
    wr_check(32'h0000_0004, er, et, h, rq, "R8");
    // R8 writing zeros changes nothing
    wr_check(32'h0000_0000, er, et, h, rq, "R8");
    // R9 reload from strap defaults
    h = ~cn;
    wr_check(32'h0000_0100, er, et, h, rq, "R9");
    // R11 R10 write all ones except reload: read-only bits keep, reserved read 0
    wr_check(32'hFFFF_FEFF, 1'b0, et, 2'b00, rq, "R11");
    // R9 reload wins over a clear in the same write
    wr_check(32'h0000_010C, 1'b0, et, ~cn, rq, "R9");
  endtask

  initial begin
    for (int c = 0; c < 32; c++)
      for (int m = 0; m < 3; m++)
        run(c, m);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule